// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a single-channel 32-bit up-counter that software drives through a small register port. A control word starts and stops counting and gates the interrupt. A compare word holds a one-shot deadline, and a count word exposes the running value, which software may also overwrite. When the running count equals the deadline while counting is on, a sticky pending flag is raised. If the interrupt gate is open, that flag drives a level interrupt line.

The pending flag lives in the same control word as the two enable bits and is cleared by writing a one to it. A read-modify-write of the control word therefore clears any event that is pending. A typical use arms one deadline as follows: stop the channel, zero the count, load the compare word, and then write the control word with both enables set and the clear bit set.

The enable bit and the pending flag are held together in one four-state channel machine. The states are `CH_IDLE` (stopped, nothing pending), `CH_RUN` (counting, nothing pending), `CH_RUN_HIT` (counting, event pending) and `CH_HALT_HIT` (stopped, event pending). The transitions are as follows:
- start: `CH_IDLE` to `CH_RUN`.
- stop: `CH_RUN` to `CH_IDLE`, or `CH_RUN_HIT` to `CH_HALT_HIT`.
- hit: `CH_RUN` to `CH_RUN_HIT`, or to `CH_HALT_HIT` when a stop arrives in the same cycle.
- acknowledge: `CH_RUN_HIT` or `CH_HALT_HIT` to `CH_RUN` or `CH_IDLE`, depending on the enable value written.
- resume: `CH_HALT_HIT` to `CH_RUN_HIT`.

Top module: `cmp_timer`

## Requirements
- R1: Register byte offsets are 0x0 for control, 0x4 for compare and 0x8 for count. A read strobe returns the addressed word on `rd_data` one clock later, and `rd_data` holds that value until the next read.
- R2: Control word layout: bit 0 is the pending flag, bit 1 is the interrupt gate and bit 2 is the counter enable. All other control bits read as zero, and writing them has no effect.
- R3: While enabled, the count rises by one every clock and wraps from 0xFFFFFFFF to 0. While disabled, it holds its value.
- R4: A write to the count word loads the written value at the next edge and takes precedence over that cycle's increment.
- R5: The pending flag is set at the clock edge that ends a cycle in which counting is enabled and count equals compare. This holds for any compare value, including 0xFFFFFFFF.
- R6: Writing 1 to control bit 0 clears the pending flag. Writing 0 there leaves it unchanged, and nothing else clears it.
- R7: When a match and a clearing write occur in the same cycle, the flag remains set.
- R8: `irq` is high exactly when the pending flag and the interrupt gate are both set. It is a level signal that follows either bit without delay.
- R9: Reads of any offset other than 0x0, 0x4 or 0x8 return zero, and writes to such offsets change no register.
- R10: After reset, all three registers read zero and `irq` is low.
- R11: Writing zero to control, count and compare in that order leaves the count frozen at zero, with no pending event arising afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Byte offset of the accessed register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a clearing control write that lands on the exact edge at which a match sets the flag. The stimulus first stops the channel and loads count and compare with the same value. It then starts counting and issues the clearing write on the very next cycle, so that the match cycle and the write coincide. A sweep over start values near zero, mid-range and just below the wrap point, combined with compare offsets 0 to 11, checks `irq` on every cycle around the deadline. This confirms that the flag rises exactly one edge after the matching cycle, including when the deadline falls at 0xFFFFFFFF.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int unsigned OFS_CTRL = 0;
    localparam int unsigned OFS_CMP  = 4;
    localparam int unsigned OFS_CNT  = 8;

    localparam int unsigned BIT_PEND = 0;
    localparam int unsigned BIT_IE   = 1;
    localparam int unsigned BIT_EN   = 2;

    typedef enum logic [1:0] {
        CH_IDLE     = 2'b00,
        CH_RUN      = 2'b01,
        CH_RUN_HIT  = 2'b11,
        CH_HALT_HIT = 2'b10
    } ch_state_e;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              run_en,
    input  logic              pend,
    output logic              ctl_wr,
    output logic              cnt_wr,
    output logic [DATA_W-1:0] cmp_q,
    output logic              irq_en,
    output logic [DATA_W-1:0] rd_data
);
    import cmp_timer_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);

    logic              cmp_wr;
    logic [DATA_W-1:0] rd_mux;

    assign ctl_wr = wr_en && (addr == A_CTRL);
    assign cmp_wr = wr_en && (addr == A_CMP);
    assign cnt_wr = wr_en && (addr == A_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            irq_en <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q  <= wr_data;
            if (ctl_wr) irq_en <= wr_data[BIT_IE];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == A_CTRL) begin
            rd_mux[BIT_PEND] = pend;
            rd_mux[BIT_IE]   = irq_en;
            rd_mux[BIT_EN]   = run_en;
        end else if (addr == A_CMP) begin
            rd_mux = cmp_q;
        end else if (addr == A_CNT) begin
            rd_mux = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] cnt_q,
    output logic              match
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (run_en) cnt_q <= cnt_q + ONE;
    end

    assign match = run_en && (cnt_q == cmp_val);
endmodule

// File: rtl/cmp_timer_fsm.sv
module cmp_timer_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic set_en,
    input  logic clr_req,
    input  logic match,
    output logic run_en,
    output logic pend
);
    import cmp_timer_pkg::*;

    ch_state_e state_q, state_d;
    logic      ack;

    assign ack = ctl_wr && clr_req && !match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ctl_wr && set_en) state_d = CH_RUN;             // start
            end
            CH_RUN: begin
                if (match)
                    state_d = (ctl_wr && !set_en) ? CH_HALT_HIT : CH_RUN_HIT; // hit
                else if (ctl_wr && !set_en)
                    state_d = CH_IDLE;                              // stop
            end
            CH_RUN_HIT: begin
                if (ack)
                    state_d = set_en ? CH_RUN : CH_IDLE;            // acknowledge
                else if (ctl_wr && !set_en)
                    state_d = CH_HALT_HIT;                          // stop
            end
            CH_HALT_HIT: begin
                if (ack)
                    state_d = set_en ? CH_RUN : CH_IDLE;            // acknowledge
                else if (ctl_wr && set_en)
                    state_d = CH_RUN_HIT;                           // resume
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        run_en = 1'b0;
        pend   = 1'b0;
        unique case (state_q)
            CH_IDLE:     begin run_en = 1'b0; pend = 1'b0; end
            CH_RUN:      begin run_en = 1'b1; pend = 1'b0; end
            CH_RUN_HIT:  begin run_en = 1'b1; pend = 1'b1; end
            CH_HALT_HIT: begin run_en = 1'b0; pend = 1'b1; end
            default:     begin run_en = 1'b0; pend = 1'b0; end
        endcase
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    import cmp_timer_pkg::*;

    logic              ctl_wr, cnt_wr, irq_en, run_en, pend, match;
    logic [DATA_W-1:0] cnt_q, cmp_q;

    cmp_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .cnt_q(cnt_q),
        .run_en(run_en), .pend(pend), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr),
        .cmp_q(cmp_q), .irq_en(irq_en), .rd_data(rd_data)
    );

    cmp_timer_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .load(cnt_wr),
        .load_val(wr_data), .cmp_val(cmp_q), .cnt_q(cnt_q), .match(match)
    );

    cmp_timer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .set_en(wr_data[BIT_EN]), .clr_req(wr_data[BIT_PEND]),
        .match(match), .run_en(run_en), .pend(pend)
    );

    assign irq = pend && irq_en;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] cmp,
    input logic              en,
    input logic              ie,
    input logic              pend,
    input logic              cnt_wr
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8);
    localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);

    logic ctl_clr, unmapped;
    assign ctl_clr  = wr_en && (addr == A_CTRL) && wr_data[0];
    assign unmapped = (addr != A_CTRL) && (addr != A_CMP) && (addr != A_CNT);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cnt_wr) |=> (cnt == $past(cnt) + ONE)) else $error("count step"); // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt)) else $error("count hold"); // R3
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CNT) |=> (cnt == $past(wr_data))) else $error("count load"); // R4
    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CMP) |=> (cmp == $past(wr_data))) else $error("compare load"); // R1
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == cmp) |=> pend) else $error("match sets pending"); // R5
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ctl_clr) |=> pend) else $error("pending sticky"); // R6
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && ie)) else $error("irq gating"); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |=> (rd_data == '0)) else $error("unmapped read"); // R9
endmodule

bind cmp_timer cmp_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .cnt(cnt_q), .cmp(cmp_q),
    .en(run_en), .ie(irq_en), .pend(pend), .cnt_wr(cnt_wr)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_bad = n_bad + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        logic [31:0] v, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 irq", {31'b0, irq}, 32'h0);
        rd(4'h0, v); chk("R10 ctrl", v, 32'h0);
        rd(4'h4, v); chk("R10 cmp", v, 32'h0);
        rd(4'h8, v); chk("R10 cnt", v, 32'h0);

        // R1 offsets and read hold
        wr(4'h4, 32'hDEADBEEF);
        wr(4'h8, 32'h0BADF00D);
        rd(4'h4, v); chk("R1 cmp read", v, 32'hDEADBEEF);
        rd(4'h8, v); chk("R1 cnt read", v, 32'h0BADF00D);
        addr = 4'h4; repeat (2) @(negedge clk);
        chk("R1 rd_data holds", rd_data, 32'h0BADF00D);

        // R2 control layout, extra bits ignored (count far from compare)
        wr(4'h8, 32'h0); wr(4'h4, 32'h8000_0000);
        wr(4'h0, 32'hFFFF_FFFE);
        rd(4'h0, v); chk("R2 ctrl bits", v, 32'h6);
        wr(4'h0, 32'hFFFF_FFF9);
        rd(4'h0, v); chk("R2 ctrl ie off", v, 32'h0);

        // R3 counting with wrap, then hold
        wr(4'h8, 32'hFFFF_FFFE);
        wr(4'h4, 32'h0000_1000);
        wr(4'h0, 32'h4);
        repeat (3) @(negedge clk);
        rd(4'h8, v); chk("R3 wrap", v, 32'h0000_0001);
        wr(4'h8, 32'h0000_0100);
        rd(4'h8, v); chk("R4 load beats increment", v, 32'h0000_0100);
        wr(4'h0, 32'h0);
        rd(4'h8, v);
        repeat (5) @(negedge clk);
        rd(4'h8, w); chk("R3 hold when off", w, v);

        // R5 sweep of start values and compare offsets
        for (int s = 0; s < 3; s++) begin
            for (int d = 0; d < 12; d++) begin
                logic [31:0] base;
                base = (s == 0) ? 32'h0 : (s == 1) ? 32'h1234_5678 : 32'hFFFF_FFF8;
                wr(4'h0, 32'h1);
                wr(4'h8, base);
                wr(4'h4, base + 32'(d));
                wr(4'h0, 32'h7);
                for (int j = 0; j <= d + 3; j++) begin
                    if (j > 0) @(negedge clk);
                    chk("R5 deadline irq", {31'b0, irq}, {31'b0, (j >= d + 1)});
                end
            end
        end

        // R6 write-0 keeps pending, write-1 clears
        wr(4'h0, 32'h6);
        chk("R6 write0 keeps irq", {31'b0, irq}, 32'h1);
        rd(4'h0, v); chk("R6 write0 keeps ctrl", v, 32'h7);
        wr(4'h0, 32'h3);
        chk("R6 write1 clears irq", {31'b0, irq}, 32'h0);
        rd(4'h0, v); chk("R6 write1 clears ctrl", v, 32'h2);

        // R7 clear coinciding with match
        wr(4'h8, 32'h40);
        wr(4'h4, 32'h40);
        wr(4'h0, 32'h6);
        wr(4'h0, 32'h7);
        chk("R7 match wins", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'h7);
        chk("R7 later clear", {31'b0, irq}, 32'h0);

        // R8 gate closed, then opened
        wr(4'h0, 32'h1);
        wr(4'h8, 32'h10);
        wr(4'h4, 32'h12);
        wr(4'h0, 32'h4);
        repeat (5) @(negedge clk);
        chk("R8 gate closed", {31'b0, irq}, 32'h0);
        rd(4'h0, v); chk("R8 pending visible", v, 32'h5);
        wr(4'h0, 32'h6);
        chk("R8 gate opened", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'h1);

        // R9 unmapped offsets
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h2, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R9 ctrl untouched", v, 32'h0);
        rd(4'h4, v); chk("R9 cmp untouched", v, 32'h12);
        rd(4'hC, v); chk("R9 read 0xC", v, 32'h0);
        rd(4'h6, v); chk("R9 read 0x6", v, 32'h0);
        chk("R9 irq", {31'b0, irq}, 32'h0);

        // R11 zeroing leaves the channel idle
        wr(4'h0, 32'h0);
        wr(4'h8, 32'h0);
        wr(4'h4, 32'h0);
        repeat (20) @(negedge clk);
        rd(4'h0, v); chk("R11 ctrl idle", v, 32'h0);
        rd(4'h8, v); chk("R11 count frozen", v, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule